// File: doc/BRIEF.md
# Floating-Point Control, Status and Exception Unit

This block keeps the control and status word of a floating-point unit and applies the exception policy to the raw events that the arithmetic datapath reports. When an operation completes, the datapath pulses a strobe with six raw event bits: invalid, divide-by-zero, overflow, tiny result, inexact and unimplemented. It also supplies an operation-class tag and, for compares, the compare outcome. One cycle later the unit reloads the per-operation cause field and accumulates the sticky flags. It then either requests a trap or grants the destination-register writeback. It also drives the current rounding mode and the compare condition bit.

A single register write port loads the whole word. A write is the only way to clear the sticky flags. A write that leaves a cause bit together with its matching enable bit set requests a trap on the following cycle.

Operation classes use the encoding 0 = arithmetic or conversion, 1 = compare, 2 or 3 = load, store or unformatted move. Word layout: bits 1..0 hold the rounding mode. Bits 6..2 hold the flags for invalid, divide-by-zero, overflow, underflow and inexact, with invalid at bit 6. Bits 11..7 hold the enables in the same order, with invalid at bit 11. Bits 17..12 hold the cause: unimplemented at bit 17, then invalid at bit 16 down to inexact at bit 12. Bit 23 is the condition bit. All other bits read as zero.

Top module: `fp_csr_unit`

## Requirements
- R1: `round_mode` always equals word bits 1..0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and a register write loads it from `wr_data[1:0]`.
- R2: An operation of class 0 or 1 reloads the cause field (bits 17..12) with the OR of all its resolved exceptions on the clock edge that samples `op_done`. An operation of class 2 or 3 leaves the cause field unchanged.
- R3: Flag bits 6..2 gain every resolved exception of a class 0 or 1 operation and are never cleared by operations. Only a register write changes them, and a write loads them from `wr_data[6:2]`.
- R4: `trap_req` is high for the one cycle after an operation of class 0 or 1 in which a resolved exception has its enable bit (bits 11..7) set.
- R5: An unimplemented event on a class 0 or 1 operation always raises `trap_req` and sets cause bit 17. It changes no flag bit.
- R6: `dest_wr_en` is high for the one cycle after a class 0 operation that takes no trap, or after any class 2 or 3 operation. It is low after compares and whenever `trap_req` is high.
- R7: With the underflow enable (bit 8) clear, underflow is resolved only when tiny and inexact are both reported. With it set, tiny alone resolves underflow.
- R8: An overflow with the overflow enable (bit 9) clear also resolves inexact. With the enable set, overflow does not add inexact.
- R9: The condition bit (bit 23, output `cond_bit`) takes `cmp_true` on a class 1 operation. It changes otherwise only through a register write.
- R10: A register write whose data has any cause bit 16..12 set together with the matching enable bit 11..7 raises `trap_req` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the word |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| op_done | input | 1 | Operation-complete strobe |
| op_class | input | 2 | Operation class tag |
| ev_unimpl | input | 1 | Raw unimplemented-operation event |
| ev_invalid | input | 1 | Raw invalid-operation event |
| ev_divzero | input | 1 | Raw divide-by-zero event |
| ev_overflow | input | 1 | Raw overflow event |
| ev_tiny | input | 1 | Raw tiny-result event |
| ev_inexact | input | 1 | Raw inexact event |
| cmp_true | input | 1 | Compare outcome |
| round_mode | output | 2 | Current rounding mode |
| trap_req | output | 1 | Trap request pulse |
| dest_wr_en | output | 1 | Destination writeback enable pulse |
| cond_bit | output | 1 | Compare condition bit |
| csr_out | output | 32 | Current register word |

## Verification
The hardest cases to reach are the ones that hinge on enable state set up several cycles earlier. A tiny-but-exact result must trap only while the underflow enable is set. An overflow must add inexact only while its enable is clear. The stimulus first writes specific enable patterns through the write port and then replays the same raw event vector under each pattern, so the resolved cause differs only through the enables. A write that plants a cause/enable pair reaches the write-induced trap without any operation at all.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int CSR_W     = 32;
    localparam int NEXC      = 5;
    localparam int FLAG_LO   = 2;
    localparam int EN_LO     = FLAG_LO + NEXC;
    localparam int CAUSE_LO  = EN_LO + NEXC;
    localparam int UNIMP_BIT = CAUSE_LO + NEXC;
    localparam int COND_POS  = 23;

    localparam logic [CSR_W-1:0] WR_MASK =
        (CSR_W'(1) << COND_POS) |
        (((CSR_W'(1) << (UNIMP_BIT + 1)) - 1));

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_PLUS    = 2'd2,
        RND_MINUS   = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_CMP   = 2'd1,
        OPC_XFER  = 2'd2,
        OPC_XFER2 = 2'd3
    } opc_e;

    typedef struct packed {
        logic unimpl;
        logic invalid;
        logic divzero;
        logic overflow;
        logic tiny;
        logic inexact;
    } raw_ev_t;

    typedef struct packed {
        logic v;
        logic z;
        logic o;
        logic u;
        logic i;
    } exc5_t;

    function automatic exc5_t resolve_exc(raw_ev_t ev, exc5_t en);
        exc5_t r;
        r.v = ev.invalid;
        r.z = ev.divzero;
        r.o = ev.overflow;
        r.u = en.u ? ev.tiny : (ev.tiny & ev.inexact);
        r.i = ev.inexact | (ev.overflow & ~en.o);
        return r;
    endfunction

    function automatic logic is_arith_or_cmp(opc_e c);
        return (c == OPC_ARITH) || (c == OPC_CMP);
    endfunction

endpackage

// File: rtl/fpcsr_event_map.sv
module fpcsr_event_map
    import fpcsr_pkg::*;
(
    input  raw_ev_t ev,
    input  exc5_t   enables,
    output exc5_t   resolved,
    output logic    op_trap
);

    always_comb begin
        resolved = resolve_exc(ev, enables);
        op_trap  = ev.unimpl | (|(resolved & enables));
    end

endmodule

// File: rtl/fpcsr_reg.sv
module fpcsr_reg
    import fpcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             cause_upd,
    input  logic             unimpl,
    input  exc5_t            resolved,
    input  logic             cmp_upd,
    input  logic             cmp_val,
    output logic [CSR_W-1:0] csr
);

    logic [CSR_W-1:0] csr_q;
    logic [CSR_W-1:0] csr_d;

    always_comb begin
        csr_d = csr_q;
        if (wr_en) begin
            csr_d = wr_data & WR_MASK;
        end else begin
            if (cause_upd) begin
                csr_d[UNIMP_BIT:CAUSE_LO]            = {unimpl, resolved};
                csr_d[FLAG_LO+NEXC-1:FLAG_LO]        = csr_q[FLAG_LO+NEXC-1:FLAG_LO] | resolved;
            end
            if (cmp_upd) begin
                csr_d[COND_POS] = cmp_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) csr_q <= '0;
        else     csr_q <= csr_d;
    end

    assign csr = csr_q;

endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
    import fpcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        op_done,
    input  logic [1:0]  op_class,
    input  logic        ev_unimpl,
    input  logic        ev_invalid,
    input  logic        ev_divzero,
    input  logic        ev_overflow,
    input  logic        ev_tiny,
    input  logic        ev_inexact,
    input  logic        cmp_true,
    output logic [1:0]  round_mode,
    output logic        trap_req,
    output logic        dest_wr_en,
    output logic        cond_bit,
    output logic [31:0] csr_out
);

    raw_ev_t          ev;
    exc5_t            en_cur;
    exc5_t            resolved;
    logic             op_trap;
    logic             exc_op;
    logic             wr_trap;
    logic [CSR_W-1:0] csr;
    opc_e             cls;
    logic             trap_q;
    logic             wen_q;

    assign cls    = opc_e'(op_class);
    assign ev     = '{unimpl: ev_unimpl, invalid: ev_invalid, divzero: ev_divzero,
                      overflow: ev_overflow, tiny: ev_tiny, inexact: ev_inexact};
    assign en_cur = exc5_t'(csr[EN_LO+NEXC-1:EN_LO]);
    assign exc_op = op_done & is_arith_or_cmp(cls);

    fpcsr_event_map u_map (
        .ev       (ev),
        .enables  (en_cur),
        .resolved (resolved),
        .op_trap  (op_trap)
    );

    fpcsr_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cause_upd (exc_op),
        .unimpl    (ev_unimpl),
        .resolved  (resolved),
        .cmp_upd   (op_done && cls == OPC_CMP),
        .cmp_val   (cmp_true),
        .csr       (csr)
    );

    assign wr_trap = wr_en &
        (|(wr_data[CAUSE_LO+NEXC-1:CAUSE_LO] & wr_data[EN_LO+NEXC-1:EN_LO]));

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            wen_q  <= 1'b0;
        end else begin
            trap_q <= (exc_op & op_trap) | wr_trap;
            wen_q  <= op_done & ((cls == OPC_ARITH) ? ~op_trap : (cls != OPC_CMP));
        end
    end

    assign trap_req   = trap_q;
    assign dest_wr_en = wen_q & ~trap_q;
    assign round_mode = csr[1:0];
    assign cond_bit   = csr[COND_POS];
    assign csr_out    = csr;

endmodule

// File: rtl/fp_csr_unit_chk.sv
module fp_csr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        op_done,
    input logic [1:0]  op_class,
    input logic        ev_unimpl,
    input logic        trap_req,
    input logic        dest_wr_en,
    input logic        cond_bit,
    input logic [31:0] csr_out
);

    a_r5_unimpl_traps: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_class[1] == 1'b0 && ev_unimpl) |=> trap_req);

    a_r6_no_wb_on_trap: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !dest_wr_en);

    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((csr_out[6:2] & $past(csr_out[6:2])) == $past(csr_out[6:2])));

    a_r9_cond_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(op_done && op_class == 2'd1)) |=> $stable(cond_bit));

    a_r2_cause_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(op_done && op_class[1] == 1'b0)) |=> $stable(csr_out[17:12]));

    a_r6_cmp_no_wb: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_class == 2'd1) |=> !dest_wr_en);

endmodule

bind fp_csr_unit fp_csr_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .op_done    (op_done),
    .op_class   (op_class),
    .ev_unimpl  (ev_unimpl),
    .trap_req   (trap_req),
    .dest_wr_en (dest_wr_en),
    .cond_bit   (cond_bit),
    .csr_out    (csr_out)
);

// File: tb/fp_csr_unit_tb_top.sv
module fp_csr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        op_done;
    logic [1:0]  op_class;
    logic        ev_unimpl, ev_invalid, ev_divzero, ev_overflow, ev_tiny, ev_inexact;
    logic        cmp_true;
    logic [1:0]  round_mode;
    logic        trap_req, dest_wr_en, cond_bit;
    logic [31:0] csr_out;

    always #2 clk = ~clk;

    fp_csr_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_class(op_class),
        .ev_unimpl(ev_unimpl), .ev_invalid(ev_invalid), .ev_divzero(ev_divzero),
        .ev_overflow(ev_overflow), .ev_tiny(ev_tiny), .ev_inexact(ev_inexact),
        .cmp_true(cmp_true), .round_mode(round_mode), .trap_req(trap_req),
        .dest_wr_en(dest_wr_en), .cond_bit(cond_bit), .csr_out(csr_out)
    );

    typedef struct {
        string       tag;
        logic        trap;
        logic        wen;
        logic [31:0] csr;
    } exp_t;

    exp_t        sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] m_csr = '0;
    bit          done  = 0;

    localparam logic [31:0] MASK = 32'h0083_FFFF;

    // ev6 order: {unimpl, invalid, divzero, overflow, tiny, inexact}
    task automatic step(input string tag, input logic w, input logic [31:0] wd,
                        input logic d, input logic [1:0] cls, input logic [5:0] ev6,
                        input logic c);
        exp_t e;
        logic [4:0] en, c5;
        logic       tr;
        @(negedge clk);
        wr_en = w; wr_data = wd; op_done = d; op_class = cls;
        {ev_unimpl, ev_invalid, ev_divzero, ev_overflow, ev_tiny, ev_inexact} = ev6;
        cmp_true = c;
        en = m_csr[11:7];
        c5[4] = ev6[4];
        c5[3] = ev6[3];
        c5[2] = ev6[2];
        c5[1] = en[1] ? ev6[1] : (ev6[1] & ev6[0]);
        c5[0] = ev6[0] | (ev6[2] & ~en[2]);
        tr = ev6[5] | (|(c5 & en));
        e.tag  = tag;
        e.trap = (d && !cls[1] && tr) || (w && |(wd[16:12] & wd[11:7]));
        e.wen  = d && ((cls == 2'd0 && !tr) || cls[1]) && !e.trap;
        if (w) begin
            m_csr = wd & MASK;
        end else if (d && !cls[1]) begin
            m_csr[17:12] = {ev6[5], c5};
            m_csr[6:2]   = m_csr[6:2] | c5;
            if (cls == 2'd1) m_csr[23] = c;
        end
        e.csr = m_csr;
        sb_q.push_back(e);
    endtask

    task automatic idle_in();
        wr_en = 0; wr_data = '0; op_done = 0; op_class = 2'd0;
        {ev_unimpl, ev_invalid, ev_divzero, ev_overflow, ev_tiny, ev_inexact} = '0;
        cmp_true = 0;
    endtask

    // monitor: pops one expectation for every step driven before this edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (trap_req !== e.trap || dest_wr_en !== e.wen || csr_out !== e.csr ||
                round_mode !== e.csr[1:0] || cond_bit !== e.csr[23]) begin
                n_bad++;
                $display("FAIL %s: trap=%0b wen=%0b csr=%h rm=%0d cond=%0b expected trap=%0b wen=%0b csr=%h",
                         e.tag, trap_req, dest_wr_en, csr_out, round_mode, cond_bit,
                         e.trap, e.wen, e.csr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog R4: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // reset state
        n_cmp++;
        if (csr_out !== 32'h0 || trap_req !== 0 || dest_wr_en !== 0 || round_mode !== 2'd0) begin
            n_bad++;
            $display("FAIL R1 reset: csr=%h trap=%0b wen=%0b expected 0", csr_out, trap_req, dest_wr_en);
        end
        // R1 rounding mode writes, unmasked bits dropped
        step("R1 mode2", 1, 32'hFF40_0002, 0, 0, 6'b0, 0);
        step("R1 mode3", 1, 32'h0000_0003, 0, 0, 6'b0, 0);
        // R6 clean arithmetic writes back
        step("R6 clean arith", 0, 0, 1, 2'd0, 6'b000000, 0);
        // R2 R3 inexact
        step("R2 inexact", 0, 0, 1, 2'd0, 6'b000001, 0);
        step("R2 invalid+divzero OR", 0, 0, 1, 2'd0, 6'b011000, 0);
        // R2 transfer class keeps cause
        step("R2 xfer keeps cause", 0, 0, 1, 2'd2, 6'b011111, 0);
        step("R2 xfer3 keeps cause", 0, 0, 1, 2'd3, 6'b000100, 0);
        // R3 flags survive a clean op
        step("R3 sticky after clean", 0, 0, 1, 2'd0, 6'b000000, 0);
        // R7 underflow untrapped
        step("R7 tiny exact untrapped", 0, 0, 1, 2'd0, 6'b000010, 0);
        step("R7 tiny inexact untrapped", 0, 0, 1, 2'd0, 6'b000011, 0);
        // R8 overflow untrapped adds inexact
        step("R8 ovf untrapped", 0, 0, 1, 2'd0, 6'b000100, 0);
        // R3 write clears flags; enable underflow (bit 8)
        step("R3 write clears", 1, 32'h0000_0100, 0, 0, 6'b0, 0);
        step("R7 tiny exact trapped", 0, 0, 1, 2'd0, 6'b000010, 0);
        step("R4 idle after trap", 0, 0, 0, 2'd0, 6'b0, 0);
        // R8 enable overflow (bit 9)
        step("R8 enable ovf", 1, 32'h0000_0200, 0, 0, 6'b0, 0);
        step("R8 ovf trapped", 0, 0, 1, 2'd0, 6'b000100, 0);
        step("R4 disabled exc no trap", 0, 0, 1, 2'd0, 6'b010001, 0);
        // R5 unimplemented with no enables
        step("R5 clear enables", 1, 32'h0000_0000, 0, 0, 6'b0, 0);
        step("R5 unimpl traps", 0, 0, 1, 2'd0, 6'b100000, 0);
        step("R5 unimpl on xfer ignored", 0, 0, 1, 2'd2, 6'b100000, 0);
        // R9 compares
        step("R9 cmp true", 0, 0, 1, 2'd1, 6'b000000, 1);
        step("R9 arith keeps cond", 0, 0, 1, 2'd0, 6'b000000, 0);
        step("R9 cmp false", 0, 0, 1, 2'd1, 6'b000000, 0);
        step("R9 write sets cond", 1, 32'h0080_0000, 0, 0, 6'b0, 0);
        // R4 compare invalid with invalid enable (bit 11)
        step("R4 enable invalid", 1, 32'h0000_0800, 0, 0, 6'b0, 0);
        step("R4 cmp invalid traps", 0, 0, 1, 2'd1, 6'b010000, 1);
        // R10 write with cause+enable pair (divzero: cause 15, enable 10)
        step("R10 write cause+en", 1, 32'h0000_8400, 0, 0, 6'b0, 0);
        step("R10 write unmatched", 1, 32'h0000_8800, 0, 0, 6'b0, 0);
        step("R10 drain", 0, 0, 0, 2'd0, 6'b0, 0);
        @(negedge clk);
        idle_in();
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule